// File: doc/BRIEF.md
# TDM Multichannel Stream Formatter

This block takes one frame of multichannel samples per sample period and sends it out as a time-division-multiplexed stream on a group of parallel data wires. The frame holds `NUM_CH` channel words. They are spread over `NUM_WIRES` wires, with `CH_PER_WIRE` channels on each wire. Every wire sends its channels in one contiguous burst of valid cycles at the start of a period of `PERIOD_LEN` cycles. The period length is the clock rate divided by the sample rate. The rest of the period is driven invalid. One valid flag qualifies all wires together.

An upstream source offers a frame with `frame_req`. The block accepts it into a single holding slot when `frame_ready` is high. A held frame is launched only at a period boundary, so a burst never starts mid-period and is never cut by invalid cycles. A request that arrives while a burst is running waits in the slot until the next period. A source that offers frames faster than one per period loses the excess frame and sets a sticky error flag. The burst in flight and the held frame are not disturbed.

The period counter starts at offset 0 when reset is released. Offset is the number of cycles since reset release, taken modulo `PERIOD_LEN`.

Top module: `tdm_stream_formatter`

## Requirements
- R1: While and after reset, `out_valid` is 0, `out_data` is 0, `overrun_err` is 0 and `frame_ready` is 1.
- R2: `out_valid` is 0 in every cycle whose period offset is `CH_PER_WIRE` or more, and in every period for which no frame was launched.
- R3: A launched frame drives `out_valid` high in exactly the cycles at offsets 0 through `CH_PER_WIRE-1` of its period, with no invalid cycle between them.
- R4: Channel k of a frame is `frame_data[k*DATA_W +: DATA_W]`. Wire w is `out_data[w*DATA_W +: DATA_W]`. At valid beat b (0-based) of a burst, wire w carries channel `w*CH_PER_WIRE + b`, so each wire sends its channels in ascending order.
- R5: `out_data` is all zero in every cycle where `out_valid` is 0.
- R6: A frame accepted in a cycle at offset p is sent in the next period when p is not `PERIOD_LEN-1`. A frame accepted at offset `PERIOD_LEN-1` is sent one period later.
- R7: `frame_ready` is low exactly while a frame is held and the current offset is not `PERIOD_LEN-1`. At offset `PERIOD_LEN-1` a new frame is accepted even if one is held, because the held frame launches on that edge.
- R8: A request made while `frame_ready` is low is dropped. It sets `overrun_err`, which stays 1 until reset. The held frame and the burst in flight are sent unchanged.
- R9: A source that offers one frame per period gets back-to-back bursts in consecutive periods with no error. The valid/invalid pattern then repeats identically every period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_req | input | 1 | Offers the frame on `frame_data` |
| frame_data | input | NUM_CH*DATA_W | Frame of channel words, channel 0 in the low bits |
| frame_ready | output | 1 | The frame offered in this cycle will be accepted |
| out_valid | output | 1 | Qualifies all output wires for this cycle |
| out_data | output | NUM_WIRES*DATA_W | Output wires, wire 0 in the low bits |
| overrun_err | output | 1 | Sticky flag: a frame was offered while the slot was busy |

## Verification
The properties assume that `frame_req` is meaningful only when sampled at a clock edge. They also assume that a dropped request has no side effect beyond the error flag. The properties therefore hold for any request pattern, including overruns.

The stimulus changes inputs only between edges. It offers frames at every period offset, including the boundary offset `PERIOD_LEN-1`, so that the hold and launch rules are exercised. It deliberately offers a second frame while one is held in order to provoke the overrun. The stimulus then applies reset again, so that the sticky flag is cleared before later checks.

// File: rtl/tdm_fmt_pkg.sv
package tdm_fmt_pkg;

    // Index width that stays at least one bit for degenerate counts.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_phase_ctr.sv
module tdm_phase_ctr #(
    parameter int PERIOD_LEN = 4,
    parameter int PH_W       = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            wrap_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD_LEN - 1);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        wrap_o  = (phase_q == LAST);
        phase_d = wrap_o ? '0 : phase_q + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/tdm_frame_slot.sv
module tdm_frame_slot #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [FRAME_W-1:0] data_i,
    input  logic               wrap_i,
    output logic               ready_o,
    output logic               held_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               err_o
);
    typedef struct packed {
        logic               held;
        logic [FRAME_W-1:0] frame;
        logic               err;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d  = slot_q;
        // The slot empties on every period boundary: a held frame leaves.
        ready_o = !slot_q.held || wrap_i;
        if (wrap_i) slot_d.held = 1'b0;
        if (req_i) begin
            if (ready_o) begin
                slot_d.held  = 1'b1;
                slot_d.frame = data_i;
            end else begin
                slot_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign held_o  = slot_q.held;
    assign frame_o = slot_q.frame;
    assign err_o   = slot_q.err;
endmodule

// File: rtl/tdm_lane_mux.sv
module tdm_lane_mux #(
    parameter int CH_PER_WIRE = 2,
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 2
) (
    input  logic [CH_PER_WIRE*DATA_W-1:0] lane_frame_i,
    input  logic [IDX_W-1:0]              beat_i,
    output logic [DATA_W-1:0]             word_o
);
    always_comb begin
        word_o = '0;
        for (int j = 0; j < CH_PER_WIRE; j++) begin
            if (beat_i == IDX_W'(j)) word_o = lane_frame_i[j*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/tdm_stream_formatter.sv
module tdm_stream_formatter
    import tdm_fmt_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int NUM_WIRES   = 2,
    parameter int CH_PER_WIRE = 2,
    parameter int PERIOD_LEN  = 4,
    parameter int DATA_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_req,
    input  logic [NUM_CH*DATA_W-1:0]    frame_data,
    output logic                        frame_ready,
    output logic                        out_valid,
    output logic [NUM_WIRES*DATA_W-1:0] out_data,
    output logic                        overrun_err
);
    localparam int FRAME_W = NUM_CH * DATA_W;
    localparam int LANE_W  = CH_PER_WIRE * DATA_W;
    localparam int OUT_W   = NUM_WIRES * DATA_W;
    localparam int PH_W    = idx_w(PERIOD_LEN);
    localparam int BT_W    = idx_w(CH_PER_WIRE + 1);
    localparam logic [BT_W-1:0] BEATS = BT_W'(CH_PER_WIRE);

    if (NUM_WIRES * CH_PER_WIRE != NUM_CH || CH_PER_WIRE > PERIOD_LEN ||
        CH_PER_WIRE < 1 || PERIOD_LEN < 1) begin : g_bad_params
        $error("tdm_stream_formatter: wires*channels_per_wire must equal channels and fit in the period");
    end

    typedef struct packed {
        logic               valid;
        logic [BT_W-1:0]    beat;
        logic [FRAME_W-1:0] act;
        logic [OUT_W-1:0]   data;
    } fmt_state_t;

    fmt_state_t st_d, st_q;

    logic [PH_W-1:0]    phase_q;
    logic               wrap;
    logic               pend_valid;
    logic [FRAME_W-1:0] pend_frame;
    logic               launch;
    logic [FRAME_W-1:0] src_frame;
    logic [BT_W-1:0]    src_idx;
    logic [OUT_W-1:0]   lane_word;

    tdm_phase_ctr #(
        .PERIOD_LEN (PERIOD_LEN),
        .PH_W       (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase_q),
        .wrap_o  (wrap)
    );

    tdm_frame_slot #(
        .FRAME_W (FRAME_W)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (frame_req),
        .data_i  (frame_data),
        .wrap_i  (wrap),
        .ready_o (frame_ready),
        .held_o  (pend_valid),
        .frame_o (pend_frame),
        .err_o   (overrun_err)
    );

    assign launch = wrap && pend_valid;

    // A launch reads beat 0 of the held frame; later beats read the frame in flight.
    always_comb begin
        if (launch) begin
            src_frame = pend_frame;
            src_idx   = '0;
        end else begin
            src_frame = st_q.act;
            src_idx   = st_q.beat;
        end
    end

    for (genvar w = 0; w < NUM_WIRES; w++) begin : g_lane
        tdm_lane_mux #(
            .CH_PER_WIRE (CH_PER_WIRE),
            .DATA_W      (DATA_W),
            .IDX_W       (BT_W)
        ) u_lane (
            .lane_frame_i (src_frame[w*LANE_W +: LANE_W]),
            .beat_i       (src_idx),
            .word_o       (lane_word[w*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.data  = '0;
        if (launch) begin
            st_d.valid = 1'b1;
            st_d.beat  = BT_W'(1);
            st_d.act   = pend_frame;
            st_d.data  = lane_word;
        end else if (st_q.valid && st_q.beat < BEATS) begin
            st_d.valid = 1'b1;
            st_d.beat  = st_q.beat + BT_W'(1);
            st_d.data  = lane_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
endmodule

// File: rtl/tdm_fmt_checker.sv
module tdm_fmt_checker #(
    parameter int CH_PER_WIRE = 2,
    parameter int PERIOD_LEN  = 4,
    parameter int OUT_W       = 16,
    parameter int PH_W        = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_req,
    input logic             frame_ready,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             overrun_err,
    input logic [PH_W-1:0]  phase,
    input logic             pending
);
    p_valid_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(phase) < CH_PER_WIRE);

    p_run_unbroken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(phase) < CH_PER_WIRE - 1) |=> out_valid);

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_data == '0);

    p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && phase == PH_W'(PERIOD_LEN - 1)) |=> (out_valid && phase == '0));

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && frame_ready) |=> pending);

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_req && !frame_ready) |=> overrun_err);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> overrun_err);
endmodule

bind tdm_stream_formatter tdm_fmt_checker #(
    .CH_PER_WIRE (CH_PER_WIRE),
    .PERIOD_LEN  (PERIOD_LEN),
    .OUT_W       (NUM_WIRES * DATA_W),
    .PH_W        (tdm_fmt_pkg::idx_w(PERIOD_LEN))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_req   (frame_req),
    .frame_ready (frame_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .overrun_err (overrun_err),
    .phase       (phase_q),
    .pending     (pend_valid)
);

// File: tb/test_tdm_stream_formatter.sv
module test_tdm_stream_formatter;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int P  = 2;
    localparam int C  = 2;
    localparam int T  = 4;
    localparam int DW = 8;
    localparam int FW = N * DW;
    localparam int NV = 6;

    localparam logic [FW-1:0] VEC_FRAME [0:NV-1] = '{
        32'h44332211, 32'hA0B0C0D0, 32'h0F1E2D3C, 32'hFF00FF00, 32'h12345678, 32'h80402010
    };
    localparam int VEC_PHASE [0:NV-1] = '{0, 1, 2, 3, 3, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_req = 1'b0;
    logic [FW-1:0] frame_data = '0;
    logic          frame_ready;
    logic          out_valid;
    logic [P*DW-1:0] out_data;
    logic          overrun_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit mon_on  = 1'b0;
    bit exp_err = 1'b0;
    bit            sched_v [0:255];
    logic [FW-1:0] sched_f [0:255];

    tdm_stream_formatter #(
        .NUM_CH (N), .NUM_WIRES (P), .CH_PER_WIRE (C), .PERIOD_LEN (T), .DATA_W (DW)
    ) i_tdm_stream_formatter (
        .clk (clk), .rst_n (rst_n), .frame_req (frame_req), .frame_data (frame_data),
        .frame_ready (frame_ready), .out_valid (out_valid), .out_data (out_data),
        .overrun_err (overrun_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-cycle monitor, sampled shortly after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (mon_on) begin
            int k;
            int off;
            bit ev;
            k   = cyc / T;
            off = cyc % T;
            ev  = (k < 256) && sched_v[k] && (off < C);
            if (ev) begin
                chk(out_valid == 1'b1, "R3 burst valid", 64'(out_valid), 64'd1);
                for (int w = 0; w < P; w++) begin
                    chk(out_data[w*DW +: DW] == sched_f[k][(w*C+off)*DW +: DW], "R4 wire channel",
                        64'(out_data[w*DW +: DW]), 64'(sched_f[k][(w*C+off)*DW +: DW]));
                end
            end else begin
                chk(out_valid == 1'b0, "R2 invalid cycle", 64'(out_valid), 64'd0);
                chk(out_data == '0, "R5 idle data zero", 64'(out_data), 64'd0);
            end
            chk(overrun_err == exp_err, "R8 error flag", 64'(overrun_err), 64'(exp_err));
        end
    end

    task automatic wait_phase(input int p);
        @(negedge clk);
        while (cyc % T != p) @(negedge clk);
    endtask

    // Offer a frame at the current falling edge and record when it must appear.
    task automatic offer(input logic [FW-1:0] f, input bit exp_ready);
        int ph;
        int start;
        ph = cyc % T;
        chk(frame_ready == exp_ready, "R7 ready", 64'(frame_ready), 64'(exp_ready));
        if (exp_ready) begin
            start = (cyc / T + 1) * T + ((ph == T - 1) ? T : 0); // R6
            sched_v[start / T] = 1'b1;
            sched_f[start / T] = f;
        end else begin
            exp_err = 1'b1;
        end
        frame_req  = 1'b1;
        frame_data = f;
        @(negedge clk);
        frame_req  = 1'b0;
        frame_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        mon_on = 1'b0;
        rst_n  = 1'b0;
        exp_err = 1'b0;
        for (int i = 0; i < 256; i++) begin
            sched_v[i] = 1'b0;
            sched_f[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        chk(out_data == '0, "R1 reset data", 64'(out_data), 64'd0);
        chk(overrun_err == 1'b0, "R1 reset error", 64'(overrun_err), 64'd0);
        chk(frame_ready == 1'b1, "R1 reset ready", 64'(frame_ready), 64'd1);
        rst_n  = 1'b1;
        mon_on = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        // Table of frames offered at assorted period offsets.
        for (int i = 0; i < NV; i++) begin
            wait_phase(VEC_PHASE[i]);
            offer(VEC_FRAME[i], 1'b1);
            repeat (3 * T) @(negedge clk);
        end

        // R7: held frame blocks mid-period, boundary offset still accepts.
        wait_phase(1);
        offer(32'hCAFEF00D, 1'b1);
        chk(frame_ready == 1'b0, "R7 held blocks", 64'(frame_ready), 64'd0);
        wait_phase(T - 1);
        offer(32'h5A5AA5A5, 1'b1);
        repeat (3 * T) @(negedge clk);

        // R9: one frame per period gives consecutive bursts.
        for (int i = 0; i < 4; i++) begin
            wait_phase(2);
            offer(32'h01020304 + 32'(i) * 32'h11111111, 1'b1);
        end
        repeat (3 * T) @(negedge clk);
        chk(overrun_err == 1'b0, "R9 no error when paced", 64'(overrun_err), 64'd0);

        // R8: second frame while one is held is dropped, flag sticks.
        wait_phase(1);
        offer(32'hDEADBEEF, 1'b1);
        offer(32'h0BADF00D, 1'b0);
        repeat (4 * T) @(negedge clk);
        chk(overrun_err == 1'b1, "R8 sticky error", 64'(overrun_err), 64'd1);

        // R1: reset clears the sticky flag.
        do_reset();
        repeat (2 * T) @(negedge clk);
        chk(overrun_err == 1'b0, "R1 error cleared", 64'(overrun_err), 64'd0);

        mon_on = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule